// File: doc/BRIEF.md
# Dual-Slope Conversion Cycle Sequencer

This block is the digital controller of an integrating dual-slope converter. It steps an external analog front end through four phases in a fixed order, and for each phase it raises exactly one switch enable: auto-zero (`PH_AZ`), signal integrate (`PH_SI`), reference de-integrate (`PH_RI`) and integrator zero (`PH_IZ`). A fifth state, `PH_HOLD`, parks the front end in its auto-zero configuration while a finished result is held. During de-integration the block counts clocks against a synchronous comparator bit. At the end of the cycle it latches a five-digit BCD reading, the input polarity, and the over-range and under-range flags.

The state transitions are as follows. In `PH_HOLD`, a rising edge on `run_hold_i` moves the block to `PH_AZ`. `PH_AZ` moves to `PH_SI` when auto-zero ends. `PH_SI` moves to `PH_RI` after a fixed number of clocks. `PH_RI` moves to `PH_IZ` either on the zero crossing or on the de-integrate timeout. `PH_IZ` moves to `PH_AZ` if `run_hold_i` is high and to `PH_HOLD` otherwise. Reset enters `PH_AZ` with the long one-shot auto-zero length.

In continuous mode, auto-zero takes whatever clocks remain in the cycle, so signal-integrate starts stay a constant period apart. `BUSY` is high through signal integrate and de-integrate, which lets a host pick up the reading when `BUSY` falls.

Top module: `dslope_sequencer`

## Requirements
- R1: Each state drives exactly one switch enable. `PH_AZ` and `PH_HOLD` drive `sw_az_o`, `PH_SI` drives `sw_input_o`, `PH_RI` drives `sw_refp_o` when polarity is 1 and `sw_refn_o` when polarity is 0, and `PH_IZ` drives `sw_izero_o`. The phases follow the order AZ, SI, RI, IZ.
- R2: `busy_o` rises on the clock edge that leaves auto-zero and never while auto-zero is active. Signal integrate lasts exactly SIG_LEN clocks, measured from the rise of `busy_o` to the rise of the reference enable.
- R3: `polarity_o` takes the value of `cmp_i` in the last signal-integrate clock, where 1 means positive. It is 1 after reset, holds through a zero reading, and changes only when a signal-integrate phase ends.
- R4: The first de-integrate clock is never counted. If `cmp_i` first differs from polarity in de-integrate clock j (the first such clock is j=0), the reading is j and `busy_o` falls at clock j+2.
- R5: The BCD result loads on the first clock after `busy_o` falls. Digit d occupies bits 4d+3..4d, with the least significant digit in bits 3..0, and each digit stays in the range 0 to 9.
- R6: If no crossing is seen within REF_LEN de-integrate clocks, de-integrate ends, the reading is REF_LEN-1, and `overrange_o` sets together with the result. `overrange_o` stays set until the next de-integrate starts. A crossing in the last de-integrate clock gives a normal reading of REF_LEN-2.
- R7: `underrange_o` sets at result load when the reading is UR_LIM or less. It clears when the next signal integrate starts.
- R8: Integrator zero lasts IZ_LEN clocks, or IZ_OVR_LEN clocks after an over-range result.
- R9: With `run_hold_i` high, `busy_o` rises every CYCLE_LEN clocks, including after an over-range cycle.
- R10: When `run_hold_i` is low at the end of integrator zero, the block enters `PH_HOLD`. From then on `busy_o` stays low, `sw_az_o` stays high and the outputs do not change.
- R11: In `PH_HOLD`, a rising edge on `run_hold_i` starts one cycle. Its auto-zero lasts AZ_SINGLE clocks, so `busy_o` rises AZ_SINGLE+1 clocks after the clock in which the level went high.
- R12: A pulse on `run_hold_i` during a cycle that will end in hold has no effect. The block still enters `PH_HOLD` and stays there.
- R13: While reset is held, `busy_o` is 0, `sw_az_o` is 1, `polarity_o` is 1, both range flags are 0 and the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low reset |
| cmp_i | input | 1 | Synchronous comparator bit; 1 when the integrator is on the positive side |
| run_hold_i | input | 1 | High for continuous conversions; a rising edge while held starts one cycle |
| sw_input_o | output | 1 | Input switch enable (signal integrate) |
| sw_refp_o | output | 1 | Positive reference switch enable |
| sw_refn_o | output | 1 | Negative reference switch enable |
| sw_az_o | output | 1 | Auto-zero switch enable (also active while held) |
| sw_izero_o | output | 1 | Integrator-zero switch enable |
| busy_o | output | 1 | High from the start of signal integrate until the crossing |
| polarity_o | output | 1 | Input polarity, 1 = positive |
| overrange_o | output | 1 | Last reading exceeded the de-integrate window |
| underrange_o | output | 1 | Last reading was at or below UR_LIM |
| result_bcd_o | output | 4*DIGITS | Latched reading, packed BCD |

## Verification
The bench builds the block with SIG_LEN=100, REF_LEN=201, IZ_LEN=4, IZ_OVR_LEN=62, AZ_SINGLE=101, CYCLE_LEN=402 and UR_LIM=18. These shrunk values keep the relations between phases the same as the defaults. With them, the full cycle period, the stretched integrator zero after an over-range, the under-range boundary at 18/19, the last normal reading of 199 and the timeout reading of 200 all fall within a few thousand clocks. The comparator is driven from a behavioural integrator that flips after a chosen number of de-integrate clocks, so each expected reading is known in advance.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [2:0] {
        PH_HOLD = 3'd0,
        PH_AZ   = 3'd1,
        PH_SI   = 3'd2,
        PH_RI   = 3'd3,
        PH_IZ   = 3'd4
    } phase_e;

    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/dslope_bcd_counter.sv
module dslope_bcd_counter #(
    parameter int DIGITS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_i,
    input  logic                  inc_i,
    output logic [4*DIGITS-1:0]   bcd_o
);
    logic [DIGITS:0] carry;

    assign carry[0] = inc_i;

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        logic [3:0] dig;

        assign carry[d+1] = carry[d] && (dig == 4'd9);
        assign bcd_o[4*d +: 4] = dig;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dig <= 4'd0;
            end else if (clr_i) begin
                dig <= 4'd0;
            end else if (carry[d]) begin
                dig <= (dig == 4'd9) ? 4'd0 : dig + 4'd1;
            end
        end

        AST_BCD_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
            dig <= 4'd9); // R5
    end

endmodule

// File: rtl/dslope_phase_ctrl.sv
module dslope_phase_ctrl
    import dslope_pkg::*;
#(
    parameter int SIG_LEN    = 10000,
    parameter int REF_LEN    = 20001,
    parameter int IZ_LEN     = 200,
    parameter int IZ_OVR_LEN = 6200,
    parameter int AZ_SINGLE  = 10001,
    parameter int CYCLE_LEN  = 40002,
    localparam int CW        = cnt_width(CYCLE_LEN),
    localparam int BW        = cnt_width(REF_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmp_i,
    input  logic          run_hold_i,
    output logic          sw_input_o,
    output logic          sw_refp_o,
    output logic          sw_refn_o,
    output logic          sw_az_o,
    output logic          sw_izero_o,
    output logic          busy_o,
    output logic          pol_o,
    output logic          cnt_clr_o,
    output logic          cnt_inc_o,
    output logic [BW-1:0] cnt_bin_o,
    output logic          load_o,
    output logic          ovr_pend_o,
    output logic          ri_start_o,
    output logic          si_start_o
);
    localparam logic [CW-1:0] SIG_LAST = CW'(SIG_LEN - 1);
    localparam logic [CW-1:0] REF_LAST = CW'(REF_LEN - 1);
    localparam logic [CW-1:0] IZ_LAST  = CW'(IZ_LEN - 1);
    localparam logic [CW-1:0] IZO_LAST = CW'(IZ_OVR_LEN - 1);
    localparam logic [CW-1:0] AZ_LAST  = CW'(AZ_SINGLE - 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(CYCLE_LEN - 1);

    phase_e        state, next;
    logic [CW-1:0] ph_cnt;
    logic [CW-1:0] pos;
    logic          single_az;
    logic          cmp_q;
    logic          pol_q;
    logic          ovr_pend;
    logic          load_q;
    logic          rh_q;
    logic [BW-1:0] cnt_bin;
    logic          ri_cross;

    // next-state decision
    always_comb begin
        ri_cross = (state == PH_RI) && (ph_cnt != '0) && (cmp_q != pol_q);
        next = state;
        unique case (state)
            PH_HOLD: if (run_hold_i && !rh_q) next = PH_AZ;
            PH_AZ:   if (single_az ? (ph_cnt == AZ_LAST) : (pos == CYC_LAST)) next = PH_SI;
            PH_SI:   if (ph_cnt == SIG_LAST) next = PH_RI;
            PH_RI:   if (ri_cross || (ph_cnt == REF_LAST)) next = PH_IZ;
            PH_IZ:   if (ph_cnt == (ovr_pend ? IZO_LAST : IZ_LAST))
                         next = run_hold_i ? PH_AZ : PH_HOLD;
            default: next = PH_HOLD;
        endcase
    end

    // state register and phase bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= PH_AZ;
            ph_cnt    <= '0;
            pos       <= '0;
            single_az <= 1'b1;
            cmp_q     <= 1'b0;
            pol_q     <= 1'b1;
            ovr_pend  <= 1'b0;
            load_q    <= 1'b0;
            rh_q      <= 1'b0;
            cnt_bin   <= '0;
        end else begin
            state  <= next;
            cmp_q  <= cmp_i;
            rh_q   <= run_hold_i;
            load_q <= (state == PH_RI) && (next == PH_IZ);

            if ((next != state) || (state == PH_HOLD)) ph_cnt <= '0;
            else                                      ph_cnt <= ph_cnt + 1'b1;

            if ((state == PH_AZ) && (next == PH_SI)) pos <= '0;
            else if (pos != CYC_LAST)                pos <= pos + 1'b1;

            if ((state == PH_HOLD) && (next == PH_AZ))    single_az <= 1'b1;
            else if ((state == PH_AZ) && (next == PH_SI)) single_az <= 1'b0;

            if ((state == PH_SI) && (next == PH_RI)) pol_q <= cmp_i;

            if ((state == PH_RI) && (next == PH_IZ)) ovr_pend <= !ri_cross;

            if ((state == PH_SI) && (next == PH_RI)) cnt_bin <= '0;
            else if (cnt_inc_o)                      cnt_bin <= cnt_bin + 1'b1;
        end
    end

    // outputs from state
    always_comb begin
        sw_input_o = (state == PH_SI);
        sw_refp_o  = (state == PH_RI) && pol_q;
        sw_refn_o  = (state == PH_RI) && !pol_q;
        sw_az_o    = (state == PH_AZ) || (state == PH_HOLD);
        sw_izero_o = (state == PH_IZ);
        busy_o     = (state == PH_SI) || (state == PH_RI);
        cnt_inc_o  = (state == PH_RI) && (ph_cnt != '0) && !ri_cross;
        ri_start_o = (state == PH_SI) && (next == PH_RI);
        si_start_o = (state == PH_AZ) && (next == PH_SI);
        cnt_clr_o  = ri_start_o;
        pol_o      = pol_q;
        load_o     = load_q;
        ovr_pend_o = ovr_pend;
        cnt_bin_o  = cnt_bin;
    end

    AST_SWITCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sw_input_o, sw_refp_o, sw_refn_o, sw_az_o, sw_izero_o}) == 1); // R1
    AST_BUSY_FROM_AZ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(state) == PH_AZ); // R2
    AST_SI_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == PH_SI) |-> $past(ph_cnt) == SIG_LAST); // R2
    AST_POL_AFTER_SI: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_q) |-> $past(state) == PH_SI); // R3
    AST_RI_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_RI) |-> ph_cnt <= REF_LAST); // R6
    AST_HOLD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == PH_HOLD) |-> !$past(run_hold_i)); // R10

endmodule

// File: rtl/dslope_result_reg.sv
module dslope_result_reg #(
    parameter int DIGITS = 5,
    parameter int BW     = 15,
    parameter int UR_LIM = 1800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                ovr_pend_i,
    input  logic [BW-1:0]       cnt_bin_i,
    input  logic [4*DIGITS-1:0] bcd_i,
    input  logic                ri_start_i,
    input  logic                si_start_i,
    output logic [4*DIGITS-1:0] result_o,
    output logic                overrange_o,
    output logic                underrange_o
);
    localparam logic [BW-1:0] UR_V = BW'(UR_LIM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o     <= '0;
            overrange_o  <= 1'b0;
            underrange_o <= 1'b0;
        end else begin
            if (load_i) begin
                result_o     <= bcd_i;
                overrange_o  <= ovr_pend_i;
                underrange_o <= (cnt_bin_i <= UR_V);
            end else begin
                if (ri_start_i) overrange_o  <= 1'b0;
                if (si_start_i) underrange_o <= 1'b0;
            end
        end
    end

    AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ri_start_i |=> !overrange_o); // R6
    AST_UND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        si_start_i |=> !underrange_o); // R7

endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
    import dslope_pkg::*;
#(
    parameter int DIGITS     = 5,
    parameter int SIG_LEN    = 10000,
    parameter int REF_LEN    = 20001,
    parameter int IZ_LEN     = 200,
    parameter int IZ_OVR_LEN = 6200,
    parameter int AZ_SINGLE  = 10001,
    parameter int CYCLE_LEN  = 40002,
    parameter int UR_LIM     = 1800
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_i,
    input  logic                run_hold_i,
    output logic                sw_input_o,
    output logic                sw_refp_o,
    output logic                sw_refn_o,
    output logic                sw_az_o,
    output logic                sw_izero_o,
    output logic                busy_o,
    output logic                polarity_o,
    output logic                overrange_o,
    output logic                underrange_o,
    output logic [4*DIGITS-1:0] result_bcd_o
);
    localparam int BW = cnt_width(REF_LEN);

    logic          cnt_clr, cnt_inc, load, ovr_pend, ri_start, si_start;
    logic [BW-1:0] cnt_bin;
    logic [4*DIGITS-1:0] bcd_live;

    dslope_phase_ctrl #(
        .SIG_LEN    (SIG_LEN),
        .REF_LEN    (REF_LEN),
        .IZ_LEN     (IZ_LEN),
        .IZ_OVR_LEN (IZ_OVR_LEN),
        .AZ_SINGLE  (AZ_SINGLE),
        .CYCLE_LEN  (CYCLE_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_i      (cmp_i),
        .run_hold_i (run_hold_i),
        .sw_input_o (sw_input_o),
        .sw_refp_o  (sw_refp_o),
        .sw_refn_o  (sw_refn_o),
        .sw_az_o    (sw_az_o),
        .sw_izero_o (sw_izero_o),
        .busy_o     (busy_o),
        .pol_o      (polarity_o),
        .cnt_clr_o  (cnt_clr),
        .cnt_inc_o  (cnt_inc),
        .cnt_bin_o  (cnt_bin),
        .load_o     (load),
        .ovr_pend_o (ovr_pend),
        .ri_start_o (ri_start),
        .si_start_o (si_start)
    );

    dslope_bcd_counter #(.DIGITS(DIGITS)) u_bcd (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .bcd_o (bcd_live)
    );

    dslope_result_reg #(.DIGITS(DIGITS), .BW(BW), .UR_LIM(UR_LIM)) u_res (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .ovr_pend_i   (ovr_pend),
        .cnt_bin_i    (cnt_bin),
        .bcd_i        (bcd_live),
        .ri_start_i   (ri_start),
        .si_start_i   (si_start),
        .result_o     (result_bcd_o),
        .overrange_o  (overrange_o),
        .underrange_o (underrange_o)
    );

    AST_LOAD_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_bcd_o) |-> (!$past(busy_o) && $past(busy_o, 2))); // R5
    AST_OVR_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrange_o) |-> (!$past(busy_o) && $past(busy_o, 2))); // R6

endmodule

// File: tb/dslope_sequencer_bench.sv
`timescale 1ns/1ps
module dslope_sequencer_bench;
    localparam int DIGITS = 5;
    localparam int SIGL = 100, REFL = 201, IZL = 4, IZOL = 62, AZS = 101, CYC = 402, URL = 18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmp = 1'b0;
    logic rh = 1'b1;
    logic sw_in, sw_rp, sw_rn, sw_az, sw_iz, busy, pol, ovr, und;
    logic [4*DIGITS-1:0] res;

    int errors = 0, checks = 0, tick = 0;
    int last_si = -1;
    logic [4*DIGITS-1:0] prev_res = '0;
    logic prev_ovr = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) tick <= tick + 1;

    dslope_sequencer #(
        .DIGITS(DIGITS), .SIG_LEN(SIGL), .REF_LEN(REFL), .IZ_LEN(IZL),
        .IZ_OVR_LEN(IZOL), .AZ_SINGLE(AZS), .CYCLE_LEN(CYC), .UR_LIM(URL)
    ) u_dslope_sequencer (
        .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .run_hold_i(rh),
        .sw_input_o(sw_in), .sw_refp_o(sw_rp), .sw_refn_o(sw_rn),
        .sw_az_o(sw_az), .sw_izero_o(sw_iz), .busy_o(busy),
        .polarity_o(pol), .overrange_o(ovr), .underrange_o(und),
        .result_bcd_o(res)
    );

    function automatic logic [4*DIGITS-1:0] to_bcd(input int v);
        logic [4*DIGITS-1:0] r = '0;
        int x = v;
        for (int d = 0; d < DIGITS; d++) begin
            r[4*d +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0d)", req, act, exp, tick);
        end
    endtask

    // one conversion: p = polarity, j = crossing clock, orng = never cross, rh_mode 0 keep/1 drop/2 pulse
    task automatic conv(input bit p, input int j, input bit orng, input int rh_mode, input bit gap_chk);
        int t_si, t_ri, e, last, rexp;
        while (!busy) @(negedge clk);
        t_si = tick;
        cmp = p;
        chk(sw_in == 1'b1 && sw_az == 1'b0, "R1", {sw_in, sw_az}, 2'b10);
        chk(und == 1'b0, "R7", und, 0);
        chk(ovr == prev_ovr, "R6", ovr, prev_ovr);
        if (gap_chk) chk(t_si - last_si == CYC, "R9", t_si - last_si, CYC);
        last_si = t_si;
        if (rh_mode == 1) rh = 1'b0;
        if (rh_mode == 2) begin
            @(negedge clk); rh = 1'b1;
            @(negedge clk); rh = 1'b0;
        end
        while (!(sw_rp || sw_rn)) @(negedge clk);
        t_ri = tick;
        chk(t_ri - t_si == SIGL, "R2", t_ri - t_si, SIGL);
        e = orng ? REFL - 2 : j;
        last = e + 2 + (orng ? IZOL : IZL);
        rexp = orng ? REFL - 1 : j;
        for (int k = 0; k <= last; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 0) begin
                chk(pol == p, "R3", pol, p);
                chk(sw_rp == p && sw_rn == !p, "R1", {sw_rp, sw_rn}, {p, !p});
                chk(ovr == 1'b0, "R6", ovr, 0);
            end
            if (!orng && k == j) cmp = ~p;
            if (k == e + 1) chk(busy == 1'b1, "R4", busy, 1);
            if (k == e + 2) begin
                chk(busy == 1'b0 && sw_iz == 1'b1, "R4", {busy, sw_iz}, 2'b01);
                chk(res == prev_res, "R5", res, prev_res);
            end
            if (k == e + 3) begin
                chk(res == to_bcd(rexp), "R5", res, to_bcd(rexp));
                chk(ovr == orng, "R6", ovr, orng);
                chk(und == (rexp <= URL), "R7", und, (rexp <= URL));
                prev_res = res;
                prev_ovr = ovr;
            end
            if (k == last - 1) chk(sw_iz == 1'b1, "R8", sw_iz, 1);
            if (k == last) chk(sw_iz == 1'b0 && sw_az == 1'b1, "R8", {sw_iz, sw_az}, 2'b01);
        end
    endtask

    task automatic t_reset();
        chk(busy == 0 && sw_az == 1 && pol == 1 && ovr == 0 && und == 0 && res == '0, "R13",
            {busy, sw_az, pol, ovr, und}, 5'b01100);
    endtask

    task automatic t_hold_quiet(input int n, input string req);
        bit seen = 0;
        bit moved = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy || !sw_az) seen = 1;
            if (res != prev_res || ovr != prev_ovr) moved = 1;
        end
        chk(!seen, req, seen, 0);
        chk(!moved, req, moved, 0);
    endtask

    task automatic t_single_start();
        rh = 1'b1;
        @(negedge clk); rh = 1'b0;
        for (int i = 0; i < AZS - 1; i++) @(negedge clk);
        chk(busy == 1'b0, "R11", busy, 0);
        @(negedge clk);
        chk(busy == 1'b1, "R11", busy, 1);
    endtask

    initial begin
        rh = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        conv(1'b1, 37, 1'b0, 0, 1'b0);   // first cycle after reset
        conv(1'b0, 5,  1'b0, 0, 1'b1);   // negative, under-range
        conv(1'b1, 0,  1'b0, 0, 1'b1);   // zero reading keeps polarity
        conv(1'b1, 0,  1'b1, 0, 1'b1);   // over-range, stretched IZ
        conv(1'b1, 18, 1'b0, 0, 1'b1);   // R7 boundary, R9 after over-range
        conv(1'b0, 19, 1'b0, 1, 1'b1);   // above boundary, drop to hold (R10)
        t_hold_quiet(600, "R10");
        t_single_start();
        conv(1'b1, 199, 1'b0, 2, 1'b0);  // last normal reading, pulse ignored (R12)
        t_hold_quiet(600, "R12");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule